// File: doc/BRIEF.md
# Exception Entry Sequencer

This unit carries out the architectural bookkeeping a processor core needs when it enters an exception handler. Four request lines stand for the causes: non-maskable interrupt, bus fault, software trap and external interrupt. When any of them is raised while the unit is idle, the unit picks one by fixed priority. It captures the core's current program counter, delay-slot length and special registers (flags word, vector-table base, active and kernel stack pointers), and then walks a short fixed sequence.

The sequence forms the return address and the exception-status word. It reads the handler address from a vector table in memory over a valid/ready read port. It then works out the new stack pointers and the shifted flags word. All results are presented in a single cycle, together with a one-cycle completion pulse, and the core commits them in that cycle. A bus fault raised while an earlier bus fault is still being handled is treated as unrecoverable and reported on a sticky fatal output. The core signals the end of a handler with a return strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: Requests are accepted only while `busy` is low, one at a time. The priority is NMI, then bus fault, then trap, then interrupt. `busy` rises in the cycle after acceptance and stays high through the completion cycle. A request raised while busy is dropped, not queued.
- R2: For an NMI, `nrp_we` pulses with `nrp_out` equal to the captured PC, and `erp_we` stays low. The vector is 0, and flag bit 9 (machine flag) is cleared before the flags shift.
- R3: For a trap, bus fault or interrupt, `erp_we` pulses with `erp_out` equal to the captured PC minus `dslot_len`. The vector comes from `trap_vec`, `fault_vec` or `irq_vec` respectively.
- R4: `exs_out` carries the 8-bit vector at bits 15:8, and all its other bits are zero.
- R5: The handler fetch drives `rd_addr` = `ebp_in` + 4 × vector, and holds `rd_valid` and `rd_addr` steady until `rd_ready`. `new_pc` is the `rd_data` word accepted with `rd_ready`.
- R6: When flag bit 8 (user mode) was set at capture, `usp_we` pulses with `usp_out` = `sp_in`; otherwise `usp_we` stays low. `sp_out` always equals `ksp_in`.
- R7: `flags_out` keeps bits 31:30 of the (NMI-adjusted) flags and places its bits 19:0 at bits 29:10. Bits 9:0 are zero.
- R8: `done` is a single-cycle pulse. `dslot_clr` and all result outputs are valid in that same cycle.
- R9: A bus-fault request that arrives after a bus fault was accepted, and before `rfe` is pulsed while idle, sets `fatal`. That request is dropped, while other pending causes are still served. `fatal` stays high until reset.
- R10: After reset, `busy`, `done`, `rd_valid`, `fatal` and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_irq | input | 1 | External interrupt request |
| req_trap | input | 1 | Software trap request |
| req_bflt | input | 1 | Bus fault request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| trap_vec | input | 8 | Trap vector number |
| fault_vec | input | 8 | Bus fault vector number |
| irq_vec | input | 8 | Interrupt vector from the interrupt controller |
| pc_in | input | 32 | Current program counter |
| dslot_len | input | 3 | Delay-slot length in bytes, 0 when not in a slot |
| flags_in | input | 32 | Current flags word |
| ebp_in | input | 32 | Vector table base |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Saved kernel stack pointer |
| rfe | input | 1 | Handler return; ends bus-fault handling when idle |
| rd_valid | output | 1 | Vector table read request |
| rd_addr | output | 32 | Vector table read address |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| erp_we | output | 1 | Write exception return register |
| erp_out | output | 32 | Exception return address |
| nrp_we | output | 1 | Write NMI return register |
| nrp_out | output | 32 | NMI return address |
| exs_out | output | 32 | Exception-status word |
| sp_out | output | 32 | New stack pointer |
| usp_we | output | 1 | Write user stack pointer register |
| usp_out | output | 32 | User stack pointer value |
| flags_out | output | 32 | New flags word |
| dslot_clr | output | 1 | Clear the core's delay-slot state |
| fatal | output | 1 | Sticky recursive bus fault error |

## Verification
The bench raises several causes in one cycle to expose a wrong priority order; a swapped order would return the wrong vector and the wrong return register. NMIs with the machine flag set, and entries with and without a delay slot or the user flag, target a missing flag clear, a return address not rewound, and a stack swap done unconditionally. A stalling memory checks that the handler word is taken only on the ready cycle. A request poked during a busy sequence must not start a second entry. A repeated bus fault without a handler return must raise the fatal output and still let a lower-priority interrupt through, while a bus fault after a return is served normally.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int VEC_W      = 8;
    localparam int DS_W       = 3;
    localparam int NCAUSE     = 4;
    localparam int USER_POS   = 8;
    localparam int MACH_POS   = 9;
    localparam int KEEP_HI    = 2;
    localparam int FLAG_SHIFT = 10;
    localparam int EXS_POS    = 8;
    localparam int VEC_SCALE  = 2;
    localparam int MOVE_W     = XLEN - KEEP_HI - FLAG_SHIFT;

    typedef enum logic [1:0] {
        C_IRQ  = 2'd0,
        C_TRAP = 2'd1,
        C_BFLT = 2'd2,
        C_NMI  = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAVE,
        S_FETCH,
        S_UPDATE,
        S_DONE
    } state_e;

    typedef struct packed {
        cause_e             cause;
        logic [VEC_W-1:0]   vec;
        logic [XLEN-1:0]    pc;
        logic [DS_W-1:0]    dslot;
        logic [XLEN-1:0]    flags;
        logic [XLEN-1:0]    ebp;
        logic [XLEN-1:0]    sp;
        logic [XLEN-1:0]    ksp;
    } snap_t;

    function automatic logic [XLEN-1:0] shift_flags(input logic [XLEN-1:0] f);
        logic [XLEN-1:0] r;
        r = '0;
        r[XLEN-1 -: KEEP_HI] = f[XLEN-1 -: KEEP_HI];
        r[FLAG_SHIFT +: MOVE_W] = f[MOVE_W-1:0];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] status_word(input logic [VEC_W-1:0] v);
        logic [XLEN-1:0] r;
        r = '0;
        r[EXS_POS +: VEC_W] = v;
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NCAUSE-1:0] req,
    input  logic              block_bflt,
    output logic              any,
    output cause_e            cause
);
    logic [NCAUSE-1:0] live;

    always_comb begin
        live = req;
        live[C_BFLT] = req[C_BFLT] & ~block_bflt;
        any = |live;
        cause = C_IRQ;
        for (int i = 0; i < NCAUSE; i++) begin
            if (live[i]) cause = cause_e'(i);
        end
    end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_pkg::*;
(
    input  snap_t           snap,
    output logic [XLEN-1:0] ret_addr,
    output logic [XLEN-1:0] exs_word,
    output logic [XLEN-1:0] vec_addr
);
    logic [XLEN-1:0] rewind;
    logic [XLEN-1:0] offset;

    always_comb begin
        rewind   = XLEN'(snap.dslot);
        offset   = XLEN'(snap.vec) << VEC_SCALE;
        ret_addr = (snap.cause == C_NMI) ? snap.pc : snap.pc - rewind;
        exs_word = status_word(snap.vec);
        vec_addr = snap.ebp + offset;
    end
endmodule

// File: rtl/exc_mode_switch.sv
module exc_mode_switch
    import exc_pkg::*;
(
    input  snap_t           snap,
    output logic [XLEN-1:0] flags_new,
    output logic            usp_save,
    output logic [XLEN-1:0] usp_val,
    output logic [XLEN-1:0] sp_val
);
    logic [XLEN-1:0] adj;

    always_comb begin
        adj = snap.flags;
        if (snap.cause == C_NMI) adj[MACH_POS] = 1'b0;
        flags_new = shift_flags(adj);
        usp_save  = snap.flags[USER_POS];
        usp_val   = snap.sp;
        sp_val    = snap.ksp;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_irq,
    input  logic              req_trap,
    input  logic              req_bflt,
    input  logic              req_nmi,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [DS_W-1:0]   dslot_len,
    input  logic [XLEN-1:0]   flags_in,
    input  logic [XLEN-1:0]   ebp_in,
    input  logic [XLEN-1:0]   sp_in,
    input  logic [XLEN-1:0]   ksp_in,
    input  logic              rfe,
    output logic              rd_valid,
    output logic [XLEN-1:0]   rd_addr,
    input  logic              rd_ready,
    input  logic [XLEN-1:0]   rd_data,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   new_pc,
    output logic              erp_we,
    output logic [XLEN-1:0]   erp_out,
    output logic              nrp_we,
    output logic [XLEN-1:0]   nrp_out,
    output logic [XLEN-1:0]   exs_out,
    output logic [XLEN-1:0]   sp_out,
    output logic              usp_we,
    output logic [XLEN-1:0]   usp_out,
    output logic [XLEN-1:0]   flags_out,
    output logic              dslot_clr,
    output logic              fatal
);
    state_e            state;
    snap_t             snap;
    logic              in_bflt;
    logic              fatal_r;
    logic [XLEN-1:0]   ret_r, exs_r, addr_r, hpc_r, flags_r, usp_r, sp_r;
    logic              usp_save_r;

    logic              arb_any;
    cause_e            arb_cause;
    logic [VEC_W-1:0]  sel_vec;
    logic [XLEN-1:0]   fr_ret, fr_exs, fr_addr;
    logic [XLEN-1:0]   ms_flags, ms_usp, ms_sp;
    logic              ms_usp_save;

    exc_arbiter u_arb (
        .req        ({req_nmi, req_bflt, req_trap, req_irq}),
        .block_bflt (in_bflt),
        .any        (arb_any),
        .cause      (arb_cause)
    );

    exc_frame u_frame (
        .snap     (snap),
        .ret_addr (fr_ret),
        .exs_word (fr_exs),
        .vec_addr (fr_addr)
    );

    exc_mode_switch u_mode (
        .snap      (snap),
        .flags_new (ms_flags),
        .usp_save  (ms_usp_save),
        .usp_val   (ms_usp),
        .sp_val    (ms_sp)
    );

    always_comb begin
        unique case (arb_cause)
            C_NMI:   sel_vec = '0;
            C_BFLT:  sel_vec = fault_vec;
            C_TRAP:  sel_vec = trap_vec;
            default: sel_vec = irq_vec;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            snap       <= '0;
            in_bflt    <= 1'b0;
            fatal_r    <= 1'b0;
            ret_r      <= '0;
            exs_r      <= '0;
            addr_r     <= '0;
            hpc_r      <= '0;
            flags_r    <= '0;
            usp_r      <= '0;
            sp_r       <= '0;
            usp_save_r <= 1'b0;
        end else begin
            if (req_bflt && in_bflt) fatal_r <= 1'b1;
            case (state)
                S_IDLE: begin
                    if (arb_any) begin
                        snap.cause <= arb_cause;
                        snap.vec   <= sel_vec;
                        snap.pc    <= pc_in;
                        snap.dslot <= dslot_len;
                        snap.flags <= flags_in;
                        snap.ebp   <= ebp_in;
                        snap.sp    <= sp_in;
                        snap.ksp   <= ksp_in;
                        state      <= S_SAVE;
                        if (arb_cause == C_BFLT) in_bflt <= 1'b1;
                    end else if (rfe) begin
                        in_bflt <= 1'b0;
                    end
                end
                S_SAVE: begin
                    ret_r  <= fr_ret;
                    exs_r  <= fr_exs;
                    addr_r <= fr_addr;
                    state  <= S_FETCH;
                end
                S_FETCH: begin
                    if (rd_ready) begin
                        hpc_r <= rd_data;
                        state <= S_UPDATE;
                    end
                end
                S_UPDATE: begin
                    flags_r    <= ms_flags;
                    usp_r      <= ms_usp;
                    sp_r       <= ms_sp;
                    usp_save_r <= ms_usp_save;
                    state      <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        rd_valid  = (state == S_FETCH);
        rd_addr   = addr_r;
        new_pc    = hpc_r;
        erp_we    = done && (snap.cause != C_NMI);
        nrp_we    = done && (snap.cause == C_NMI);
        erp_out   = ret_r;
        nrp_out   = ret_r;
        exs_out   = exs_r;
        sp_out    = sp_r;
        usp_we    = done && usp_save_r;
        usp_out   = usp_r;
        flags_out = flags_r;
        dslot_clr = done;
        fatal     = fatal_r;
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [XLEN-1:0] rd_addr,
    input logic            erp_we,
    input logic            nrp_we,
    input logic            usp_we,
    input logic [XLEN-1:0] exs_out,
    input logic [XLEN-1:0] flags_out,
    input logic            fatal
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

    p_done_needs_busy_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    p_ret_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (erp_we ^ nrp_we));

    p_ret_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !done |-> !erp_we && !nrp_we && !usp_we);

    p_exs_shape_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (exs_out[EXS_POS-1:0] == '0) && (exs_out[XLEN-1:EXS_POS+VEC_W] == '0));

    p_flags_low_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[FLAG_SHIFT-1:0] == '0));

    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal);
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .erp_we    (erp_we),
    .nrp_we    (nrp_we),
    .usp_we    (usp_we),
    .exs_out   (exs_out),
    .flags_out (flags_out),
    .fatal     (fatal)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_irq, req_trap, req_bflt, req_nmi;
    logic [7:0]  trap_vec, fault_vec, irq_vec;
    logic [31:0] pc_in, flags_in, ebp_in, sp_in, ksp_in;
    logic [2:0]  dslot_len;
    logic        rfe;
    logic        rd_valid, rd_ready;
    logic [31:0] rd_addr, rd_data;
    logic        busy, done, erp_we, nrp_we, usp_we, dslot_clr, fatal;
    logic [31:0] new_pc, erp_out, nrp_out, exs_out, sp_out, usp_out, flags_out;

    int total = 0;
    int bad = 0;
    bit slow = 0;
    bit model_inbf = 0;
    logic [31:0] exp_addr;

    always #5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst(rst),
        .req_irq(req_irq), .req_trap(req_trap), .req_bflt(req_bflt), .req_nmi(req_nmi),
        .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
        .pc_in(pc_in), .dslot_len(dslot_len), .flags_in(flags_in),
        .ebp_in(ebp_in), .sp_in(sp_in), .ksp_in(ksp_in), .rfe(rfe),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .done(done), .new_pc(new_pc),
        .erp_we(erp_we), .erp_out(erp_out), .nrp_we(nrp_we), .nrp_out(nrp_out),
        .exs_out(exs_out), .sp_out(sp_out), .usp_we(usp_we), .usp_out(usp_out),
        .flags_out(flags_out), .dslot_clr(dslot_clr), .fatal(fatal)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] exp_flags(input logic [31:0] f, input bit nmi);
        logic [31:0] g;
        g = f;
        if (nmi) g[9] = 1'b0;
        return {g[31:30], g[19:0], 10'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory responder; also checks the fetch address (R5)
    always @(negedge clk) begin
        rd_ready = rd_valid && (!slow || ($urandom % 4 == 0));
        rd_data  = mem_word(rd_addr);
        if (rd_valid && rd_ready) check("R5 fetch address", rd_addr, exp_addr);
    end

    task automatic idle_inputs();
        req_irq = 0; req_trap = 0; req_bflt = 0; req_nmi = 0; rfe = 0;
    endtask

    // m bits: 3 nmi, 2 bus fault, 1 trap, 0 irq
    task automatic run(input logic [3:0] m, input logic [31:0] pc, input logic [31:0] flg,
                       input logic [2:0] ds, input bit poke, input bit do_rfe);
        int cause;
        logic [7:0] vec;
        logic [3:0] live;
        live = m;
        if (model_inbf) live[2] = 1'b0;
        cause = -1;
        for (int i = 0; i < 4; i++) if (live[i]) cause = i;
        trap_vec = 8'($urandom); fault_vec = 8'($urandom); irq_vec = 8'($urandom);
        ebp_in = {$urandom, 2'b00} [31:0]; sp_in = $urandom; ksp_in = $urandom;
        pc_in = pc; flags_in = flg; dslot_len = ds;
        case (cause)
            3: vec = 8'd0;
            2: vec = fault_vec;
            1: vec = trap_vec;
            default: vec = irq_vec;
        endcase
        exp_addr = ebp_in + {22'd0, vec, 2'b00};
        {req_nmi, req_bflt, req_trap, req_irq} = m;
        @(negedge clk);
        idle_inputs();
        if (m[2] && model_inbf) check("R9 fatal on recursive bus fault", {31'd0, fatal}, 32'd1);
        if (cause < 0) begin
            check("R9 recursive bus fault dropped", {31'd0, busy}, 32'd0);
            return;
        end
        if (cause == 2) model_inbf = 1;
        check("R1 busy after accept", {31'd0, busy}, 32'd1);
        if (poke) req_trap = 1;
        for (int i = 0; i < 300 && !done; i++) begin
            @(negedge clk);
            req_trap = 0;
        end
        check("R8 done pulse seen", {31'd0, done}, 32'd1);
        check("R8 dslot clear", {31'd0, dslot_clr}, 32'd1);
        check("R5 new pc", new_pc, mem_word(exp_addr));
        check("R4 status word", exs_out, {16'd0, vec, 8'd0});
        check("R7 flags shift", flags_out, exp_flags(flg, cause == 3));
        check("R6 stack pointer", sp_out, ksp_in);
        check("R6 usp write", {31'd0, usp_we}, {31'd0, flg[8]});
        if (flg[8]) check("R6 usp value", usp_out, sp_in);
        if (cause == 3) begin
            check("R2 nrp write", {30'd0, nrp_we, erp_we}, 32'd2);
            check("R2 nrp value", nrp_out, pc);
        end else begin
            check("R3 erp write", {30'd0, nrp_we, erp_we}, 32'd1);
            check("R3 erp value", erp_out, pc - {29'd0, ds});
        end
        @(negedge clk);
        check("R8 done one cycle", {31'd0, done}, 32'd0);
        check("R1 no queued request", {31'd0, busy}, 32'd0);
        if (do_rfe) begin
            rfe = 1;
            @(negedge clk);
            rfe = 0;
            model_inbf = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240917));
        idle_inputs();
        trap_vec = 0; fault_vec = 0; irq_vec = 0; pc_in = 0; flags_in = 0;
        ebp_in = 0; sp_in = 0; ksp_in = 0; dslot_len = 0; exp_addr = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        check("R10 reset outputs",
              {25'd0, busy, done, rd_valid, fatal, erp_we, nrp_we, usp_we}, 32'd0);

        // directed: single causes
        run(4'b1000, 32'h0000_1000, 32'hFFFF_FFFF, 3'd2, 0, 1); // R2 NMI clears M
        run(4'b0100, 32'h0000_2000, 32'h0000_0100, 3'd2, 0, 1); // R3 bus fault, dslot
        run(4'b0010, 32'h0000_3000, 32'h0000_0000, 3'd0, 0, 1); // R3 trap, no U
        run(4'b0001, 32'h8000_0004, 32'hC000_0300, 3'd4, 0, 1); // R3 irq
        // R1 priority
        run(4'b1111, 32'h0000_4000, 32'h0000_0100, 3'd2, 0, 1);
        run(4'b0111, 32'h0000_5000, 32'h0000_0100, 3'd0, 0, 1);
        run(4'b0011, 32'h0000_6000, 32'h0000_0000, 3'd2, 0, 1);
        // R1 hold-off during busy, R5 slow memory
        slow = 1;
        run(4'b0001, 32'h0000_7000, 32'h0000_0100, 3'd2, 1, 1);
        run(4'b1000, 32'h0000_7100, 32'h0000_0200, 3'd0, 0, 1);
        // random mix
        for (int k = 0; k < 150; k++) begin
            logic [3:0] m;
            m = 4'($urandom);
            if (m == 0) m = 4'b0001;
            slow = ($urandom % 2 == 1);
            run(m, $urandom, $urandom, 3'($urandom), ($urandom % 5 == 0), 1);
        end
        slow = 0;
        // R9 recursive bus fault
        run(4'b0100, 32'h0000_9000, 32'h0000_0000, 3'd0, 0, 0);
        check("R9 fatal low before recursion", {31'd0, fatal}, 32'd0);
        run(4'b0100, 32'h0000_9100, 32'h0000_0000, 3'd0, 0, 0);
        run(4'b0101, 32'h0000_9200, 32'h0000_0100, 3'd2, 0, 0); // irq still served
        rfe = 1; @(negedge clk); rfe = 0; model_inbf = 0;
        run(4'b0100, 32'h0000_9300, 32'h0000_0000, 3'd0, 0, 1); // served after return
        check("R9 fatal sticky", {31'd0, fatal}, 32'd1);
        finish_run();
    end
endmodule